// File: doc/BRIEF.md
# CRC Feed Sequencer

This block feeds a serial CRC shifter from an element FIFO. While shifting is enabled and the FIFO holds at least one element, it sends one bit of the head element per clock. It starts at the bit index given by the length code and steps down to bit 0. Bits above the length code are never sent. When the last bit of an element has gone out, the block pops the FIFO. Because each clock is one shift slot, an element of length code L costs exactly L+1 cycles.

The block also watches the element count. When its own pop drains the FIFO to empty, it raises a sticky interrupt flag, and that flag is gated by an enable to form the interrupt request. If the count drops to zero for any other reason, such as an overflow write that wraps the count, the flag does not move. When idle-stop is enabled and an idle request is active, the sequencer freezes and later resumes from where it stopped. Dropping the run input in the middle of an element pauses on the current bit and does not abort the element. The CRC arithmetic and the FIFO storage live outside this block.

Top module: `crcfeed_seq`

## Requirements
- R1: `shift_en_o` is 1 only when `run_i` is 1, `fifo_count_i` is nonzero and the block is not frozen. An odd byte held back by the FIFO in word mode leaves the count at 0, so it never produces a shift.
- R2: For each element, the first bit sent is `elem_data_i[len_code_i]` and later bits step down one index per shift to bit 0. Bits above index `len_code_i` never appear, and `ser_bit_o` is 0 whenever `shift_en_o` is 0.
- R3: Each element takes exactly `len_code_i`+1 shift cycles, so N elements take (`len_code_i`+1)×N shift cycles.
- R4: `fifo_pop_o` is 1 only in the shift cycle that carries bit index 0 of an element, and only together with `shift_en_o`.
- R5: After a pop leaves the count at zero, `irq_flag_o` becomes 1 on the following clock and stays 1 until it is cleared.
- R6: If the count reaches zero without a pop in the previous cycle (an overflow wrap), `irq_flag_o` stays unchanged.
- R7: While `idle_stop_en_i` and `idle_req_i` are both 1, no shift or pop happens and the bit position is kept. Shifting resumes from that position once either input is 0, and `idle_req_i` alone has no effect.
- R8: Driving `run_i` to 0 in the middle of an element holds the current bit position. When `run_i` returns to 1, the element continues from the next unsent bit.
- R9: `irq_o` equals `irq_flag_o` AND `irq_en_i`, and a 1 on `irq_clr_i` clears the flag on the next clock.
- R10: Elements written while shifting is in progress are taken in order, with no idle slot between consecutive elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one shift slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Shifting enable |
| len_code_i | input | $clog2(ELEM_W) | Polynomial length minus one; also the top bit index that is shifted |
| fifo_count_i | input | CNT_W | Number of valid elements in the FIFO |
| elem_data_i | input | ELEM_W | Head element of the FIFO |
| idle_stop_en_i | input | 1 | Freeze on idle request when 1 |
| idle_req_i | input | 1 | System idle request |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| irq_en_i | input | 1 | Interrupt enable |
| ser_bit_o | output | 1 | Serial data bit for the CRC shifter |
| shift_en_o | output | 1 | The CRC shifter takes `ser_bit_o` this cycle |
| fifo_pop_o | output | 1 | Remove the head element at this clock |
| irq_flag_o | output | 1 | Sticky drain-to-empty flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default ELEM_W=16 and CNT_W=5, so every length code from 0 to 15 can be reached. A byte-wide FIFO of depth 16 is modelled for codes up to 7, and a word-wide FIFO of depth 8 for larger codes. With these values the bench can run the 6-bit case with two ignored bits per byte, the 12-bit case with four ignored bits per word, and a full 16-bit word where an odd trailing byte is never counted. A count of 16 fills the byte FIFO exactly, and one more write wraps the count through zero without a pop.

// File: rtl/crcfeed_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the CRC feed sequencer.
// Assumes: one clock domain, each clock one shift slot.
package crcfeed_pkg;

    localparam int unsigned ELEM_W_DEF = 16;
    localparam int unsigned CNT_W_DEF  = 5;

    // Operating mode of the feed controller in the current cycle.
    typedef enum logic [1:0] {
        FEED_IDLE  = 2'd0,
        FEED_HOLD  = 2'd1,
        FEED_SHIFT = 2'd2
    } feed_mode_e;

endpackage

// File: rtl/crcfeed_bitsel.sv
`timescale 1ns/1ps
// Bit selector: returns the element bit at a given index.
// Assumes: an index at or above ELEM_W selects nothing and yields 0.
module crcfeed_bitsel #(
    parameter int ELEM_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [ELEM_W-1:0] elem_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);

    logic [ELEM_W-1:0] hit;

    // One AND term per bit position; exactly one can match the index.
    for (genvar g = 0; g < ELEM_W; g++) begin : g_tap
        assign hit[g] = elem_i[g] && (idx_i == IDX_W'(g));
    end

    // OR reduction of the matching term.
    assign bit_o = |hit;

endmodule

// File: rtl/crcfeed_ctrl.sv
`timescale 1ns/1ps
// Feed controller: tracks the bit position inside the head element,
// decides whether this cycle shifts, and pops after the final bit.
// Assumes: fifo_count_i and the head data are stable for the whole cycle.
module crcfeed_ctrl
    import crcfeed_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [IDX_W-1:0] len_code_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             freeze_i,
    output logic             shift_en_o,
    output logic             pop_o,
    output logic [IDX_W-1:0] pos_o
);

    logic             mid_q;
    logic [IDX_W-1:0] idx_q;
    feed_mode_e       mode;
    logic             last_bit;

    // Current bit index: a new element starts at the length code.
    assign pos_o = mid_q ? idx_q : len_code_i;

    // Mode decode: a freeze outranks run, and run needs a nonempty FIFO.
    always_comb begin
        if (freeze_i)
            mode = FEED_HOLD;
        else if (run_i && (count_i != '0))
            mode = FEED_SHIFT;
        else
            mode = FEED_IDLE;
    end

    assign last_bit   = (pos_o == '0);
    assign shift_en_o = (mode == FEED_SHIFT);
    assign pop_o      = shift_en_o && last_bit;

    // Position register: steps down on each shift and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q <= 1'b0;
            idx_q <= '0;
        end else if (shift_en_o) begin
            if (last_bit) begin
                mid_q <= 1'b0;
            end else begin
                mid_q <= 1'b1;
                idx_q <= pos_o - IDX_W'(1);
            end
        end
    end

    // R1: no shift without run or without data
    assert_idle_no_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || count_i == '0) |-> !shift_en_o)
        else $error("shift with run low or empty FIFO");

    // R8 (and R7): with no shift, the bit position is kept
    assert_hold_position_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_o |=> ($stable(idx_q) && $stable(mid_q)))
        else $error("position moved while not shifting");

    // R3: an element only ends through a pop
    assert_end_by_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mid_q) |-> $past(pop_o))
        else $error("element ended without pop");

endmodule

// File: rtl/crcfeed_irq.sv
`timescale 1ns/1ps
// Interrupt logic: sets a sticky flag when the FIFO count reads zero
// right after a pop, i.e. on a true drain; clears on request.
// Assumes: a pop at count one leaves the count at zero the next cycle
// unless a write arrives in the same cycle.
module crcfeed_irq #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_i,
    input  logic             en_i,
    output logic             flag_o,
    output logic             irq_o
);

    logic pop_q;
    logic drain_evt;

    // Remember whether the previous cycle popped an element.
    always_ff @(posedge clk) begin
        if (!rst_n) pop_q <= 1'b0;
        else        pop_q <= pop_i;
    end

    assign drain_evt = pop_q && (count_i == '0);

    // Sticky flag: a drain event sets it, a clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (drain_evt) flag_o <= 1'b1;
        else if (clr_i)     flag_o <= 1'b0;
    end

    assign irq_o = flag_o && en_i;

    // R5: the flag only rises after a pop
    assert_flag_after_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(pop_q))
        else $error("flag rose without a preceding pop");

    // R6: zero count with no pop before it leaves a clear flag clear
    assert_no_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == '0 && !pop_q && !flag_o) |=> !flag_o)
        else $error("flag set without a drain");

endmodule

// File: rtl/crcfeed_seq.sv
`timescale 1ns/1ps
// CRC feed sequencer top: moves FIFO elements bit by bit into a serial
// CRC shifter, most significant used bit first, and flags a drain to empty.
// Assumes: the FIFO presents its head element and count combinationally
// and removes the head at the clock where fifo_pop_o is 1.
module crcfeed_seq #(
    parameter int ELEM_W = crcfeed_pkg::ELEM_W_DEF,
    parameter int CNT_W  = crcfeed_pkg::CNT_W_DEF,
    localparam int IDX_W = $clog2(ELEM_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [IDX_W-1:0]  len_code_i,
    input  logic [CNT_W-1:0]  fifo_count_i,
    input  logic [ELEM_W-1:0] elem_data_i,
    input  logic              idle_stop_en_i,
    input  logic              idle_req_i,
    input  logic              irq_clr_i,
    input  logic              irq_en_i,
    output logic              ser_bit_o,
    output logic              shift_en_o,
    output logic              fifo_pop_o,
    output logic              irq_flag_o,
    output logic              irq_o
);

    logic             freeze;
    logic [IDX_W-1:0] pos;
    logic             sel_bit;

    // Freeze only when idle-stop is enabled and idle is requested.
    assign freeze = idle_stop_en_i && idle_req_i;

    crcfeed_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .len_code_i (len_code_i),
        .count_i    (fifo_count_i),
        .freeze_i   (freeze),
        .shift_en_o (shift_en_o),
        .pop_o      (fifo_pop_o),
        .pos_o      (pos)
    );

    crcfeed_bitsel #(.ELEM_W(ELEM_W), .IDX_W(IDX_W)) i_bitsel (
        .elem_i (elem_data_i),
        .idx_i  (pos),
        .bit_o  (sel_bit)
    );

    // Serial bit is driven only in shift slots.
    assign ser_bit_o = shift_en_o && sel_bit;

    crcfeed_irq #(.CNT_W(CNT_W)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop_i   (fifo_pop_o),
        .count_i (fifo_count_i),
        .clr_i   (irq_clr_i),
        .en_i    (irq_en_i),
        .flag_o  (irq_flag_o),
        .irq_o   (irq_o)
    );

    // R7: a frozen sequencer neither shifts nor pops
    assert_freeze_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (!shift_en_o && !fifo_pop_o))
        else $error("activity while frozen");

endmodule

// File: tb/test_crcfeed_seq.sv
`timescale 1ns/1ps
// Bench: models a byte/word FIFO, compares the serial stream with
// expected bits computed from the pushed elements and the length code.
module test_crcfeed_seq;

    localparam int ELEM_W = 16;
    localparam int CNT_W  = 5;
    localparam int IDX_W  = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0, run = 1'b0, idle_en = 1'b0, idle_req = 1'b0;
    logic              clr = 1'b0, en = 1'b1;
    logic [IDX_W-1:0]  len_code = '0;
    logic [CNT_W-1:0]  cnt = '0;
    logic [ELEM_W-1:0] data = '0;
    logic              ser_bit, shift_en, fifo_pop, irq_flag, irq;

    crcfeed_seq #(.ELEM_W(ELEM_W), .CNT_W(CNT_W)) i_crcfeed_seq (
        .clk(clk), .rst_n(rst_n), .run_i(run), .len_code_i(len_code),
        .fifo_count_i(cnt), .elem_data_i(data), .idle_stop_en_i(idle_en),
        .idle_req_i(idle_req), .irq_clr_i(clr), .irq_en_i(en),
        .ser_bit_o(ser_bit), .shift_en_o(shift_en), .fifo_pop_o(fifo_pop),
        .irq_flag_o(irq_flag), .irq_o(irq)
    );

    int tests = 0, fails = 0;
    logic [15:0] fq[$];
    logic [15:0] wq[$];
    bit expq[$];
    bit gotq[$];
    int cyc = 0, nshift = 0, first_sh = 0, last_sh = 0, bits_el = 0, badpos = 0;
    bit pop_l = 1'b0, wrap_pending = 1'b0, finished = 1'b0;
    logic [15:0] wrap_data;
    logic [7:0] half;
    bit half_valid = 1'b0;

    function automatic int depth();
        return (len_code > 4'd7) ? 8 : 16;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // FIFO model: applies pops and writes just after the clock edge.
    always begin
        logic [15:0] d;
        @(posedge clk);
        #1;
        if (pop_l && fq.size() > 0) void'(fq.pop_front());
        if (wrap_pending) begin
            fq.push_back(wrap_data);
            wrap_pending = 1'b0;
        end else if (wq.size() > 0) begin
            d = wq.pop_front();
            if (fq.size() >= depth()) begin
                fq.delete();
                wrap_data    = d;
                wrap_pending = 1'b1;
            end else begin
                fq.push_back(d);
            end
        end
        cnt  = CNT_W'(fq.size());
        data = (fq.size() > 0) ? fq[0] : '0;
    end

    // Monitor: samples outputs at the falling edge.
    always @(negedge clk) begin
        cyc++;
        pop_l = fifo_pop;
        if (shift_en) begin
            gotq.push_back(ser_bit);
            if (nshift == 0) first_sh = cyc;
            last_sh = cyc;
            nshift++;
            bits_el++;
            if (fifo_pop) begin
                if (bits_el != int'(len_code) + 1) badpos++;
                bits_el = 0;
            end
        end else begin
            if (fifo_pop) badpos++;
            if (ser_bit) badpos++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic push_elem(input logic [15:0] d);
        wq.push_back(d);
        for (int i = int'(len_code); i >= 0; i--) expq.push_back(d[i]);
    endtask

    task automatic push_byte_word(input logic [7:0] b);
        if (half_valid) begin
            push_elem({half, b});
            half_valid = 1'b0;
        end else begin
            half = b;
            half_valid = 1'b1;
        end
    endtask

    task automatic clear_flag();
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        step(1);
    endtask

    task automatic start_seg(input logic [IDX_W-1:0] lc);
        run = 1'b0;
        len_code = lc;
        clear_flag();
        gotq.delete();
        expq.delete();
        nshift = 0; badpos = 0; bits_el = 0;
    endtask

    task automatic drain();
        int guard = 0;
        run = 1'b1;
        while ((fq.size() > 0 || wq.size() > 0 || wrap_pending || shift_en) && guard < 3000) begin
            step(1);
            guard++;
        end
        step(3);
    endtask

    task automatic check_stream(input string req);
        int mism = 0;
        chk(gotq.size() == expq.size(), req, "stream length", gotq.size(), expq.size());
        for (int i = 0; i < gotq.size() && i < expq.size(); i++)
            if (gotq[i] != expq[i]) mism++;
        chk(mism == 0, req, "stream bit mismatches", mism, 0);
        chk(badpos == 0, "R4", "pop placement errors", badpos, 0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int n0, lc, ne;
        void'($urandom(32'h5EED_0C2C));
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state (R1, R5, R9)
        chk(shift_en == 1'b0, "R1", "shift_en after reset", shift_en, 0);
        chk(fifo_pop == 1'b0, "R4", "fifo_pop after reset", fifo_pop, 0);
        chk(irq_flag == 1'b0, "R5", "flag after reset", irq_flag, 0);
        chk(irq == 1'b0, "R9", "irq after reset", irq, 0);

        // 6-bit length: two ignored MSBs per byte (R2, R3, R5, R9)
        start_seg(4'd5);
        for (int i = 0; i < 4; i++) push_elem(16'($urandom_range(0, 255)));
        step(6);
        drain();
        check_stream("R2");
        chk(nshift == 24, "R3", "shift cycles len5 x4", nshift, 24);
        chk(irq_flag == 1'b1, "R5", "flag after drain", irq_flag, 1);
        chk(irq == 1'b1, "R9", "irq with enable", irq, 1);
        step(5);
        chk(irq_flag == 1'b1, "R5", "flag sticky", irq_flag, 1);
        en = 1'b0;
        step(1);
        chk(irq == 1'b0, "R9", "irq masked", irq, 0);
        en = 1'b1;
        clear_flag();
        chk(irq_flag == 1'b0, "R9", "flag cleared", irq_flag, 0);

        // 12-bit length: four ignored MSBs per word (R2, R3)
        start_seg(4'd11);
        for (int i = 0; i < 3; i++) push_elem(16'($urandom()));
        step(5);
        drain();
        check_stream("R2");
        chk(nshift == 36, "R3", "shift cycles len11 x3", nshift, 36);

        // Word mode, odd byte load: last byte never counted (R1)
        start_seg(4'd15);
        half_valid = 1'b0;
        push_byte_word(8'hA5);
        push_byte_word(8'h3C);
        push_byte_word(8'hF0);
        step(4);
        drain();
        check_stream("R1");
        chk(nshift == 16, "R3", "shift cycles one word", nshift, 16);
        chk(irq_flag == 1'b1, "R5", "flag after word drain", irq_flag, 1);
        step(20);
        chk(nshift == 16, "R1", "no shift for odd byte", nshift, 16);
        half_valid = 1'b0;

        // Run low with data present (R1)
        start_seg(4'd7);
        push_elem(16'h00C3);
        step(20);
        chk(nshift == 0, "R1", "no shift with run low", nshift, 0);
        drain();
        check_stream("R2");

        // Pause mid element (R8)
        start_seg(4'd7);
        for (int i = 0; i < 3; i++) push_elem(16'($urandom_range(0, 255)));
        step(5);
        run = 1'b1;
        step(3);
        run = 1'b0;
        step(1);
        n0 = nshift;
        step(6);
        chk(nshift == n0, "R8", "no shift while paused", nshift, n0);
        chk(bits_el != 0, "R8", "paused inside element", bits_el, 1);
        drain();
        check_stream("R8");
        chk(nshift == 24, "R8", "total shifts after pause", nshift, 24);

        // Freeze on idle (R7)
        start_seg(4'd11);
        push_elem(16'($urandom()));
        push_elem(16'($urandom()));
        step(4);
        run = 1'b1;
        step(5);
        idle_en = 1'b1;
        idle_req = 1'b1;
        step(1);
        n0 = nshift;
        step(10);
        chk(nshift == n0, "R7", "no shift while frozen", nshift, n0);
        idle_en = 1'b0;
        step(4);
        chk(nshift > n0, "R7", "idle request alone ignored", nshift, n0 + 4);
        idle_req = 1'b0;
        drain();
        check_stream("R7");

        // Writes during shifting, no gap (R10)
        start_seg(4'd7);
        push_elem(16'h0081);
        push_elem(16'h007E);
        step(4);
        run = 1'b1;
        step(4);
        for (int i = 0; i < 3; i++) push_elem(16'($urandom_range(0, 255)));
        drain();
        check_stream("R10");
        chk(last_sh - first_sh + 1 == nshift, "R10", "continuous shift span",
            last_sh - first_sh + 1, nshift);

        // Overflow wrap sets no flag (R6)
        start_seg(4'd7);
        for (int i = 0; i < 17; i++) push_elem(16'($urandom_range(0, 255)));
        step(25);
        chk(irq_flag == 1'b0, "R6", "flag after wrap", irq_flag, 0);
        chk(int'(cnt) == 1, "R6", "count after wrap", int'(cnt), 1);
        drain();
        chk(irq_flag == 1'b1, "R5", "flag after real drain", irq_flag, 1);

        // Random lengths and loads (R2, R3, R5)
        for (int it = 0; it < 16; it++) begin
            lc = $urandom_range(0, 15);
            start_seg(IDX_W'(lc));
            ne = $urandom_range(1, depth());
            for (int i = 0; i < ne; i++)
                push_elem(lc > 7 ? 16'($urandom()) : 16'($urandom_range(0, 255)));
            step(ne + 3);
            drain();
            check_stream("R2");
            chk(nshift == (lc + 1) * ne, "R3", "random shift cycles", nshift, (lc + 1) * ne);
            chk(irq_flag == 1'b1, "R5", "random drain flag", irq_flag, 1);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule